// File: doc/BRIEF.md
# Interconnect Target Agent Register Block

This block sits at the front of one peripheral on a peripheral interconnect and gives software three 32-bit registers: a fixed identification word, an agent control register and an agent status register. Software reaches them over a simple register bus. A request is presented for one cycle. The response (valid, read data and error flags) appears one cycle later.

Only a fixed set of control bits can be stored. Writing a control word with its bit 0 set asks for an agent reset. That bit is never stored. Its only effect is to clear the sticky request-timeout flag in status bit 0. A one-cycle `timeoutEvent` pulse stands in for the real timeout detector and sets that flag. The block rejects accesses that are not full 32-bit words, writes to the read-only registers, and accesses to unmapped offsets. Each of these is reported on error outputs and leaves the state unchanged.

Top module: `tgt_agent_regs`

## Requirements
- R1: After reset, control reads 0x00000200, status reads 0x00000000, and no response is signalled (`rspValid`, `rspErr` low) until a request arrives.
- R2: A word read of offset 0x00 returns the identification constant, default 0x54414731 ("TAG1", first character in bits 31:24).
- R3: A word write to offset 0x20 stores only the bits under mask 0x01000700; all other control bits read back zero, and control changes on no other access.
- R4: A word write to control with bit 0 set clears status bit 0; bit 0 itself is not stored and reads back zero.
- R5: A one-cycle `timeoutEvent` sets status bit 0, which then stays set and reads back as status value 0x00000001.
- R6: When a clearing control write and `timeoutEvent` fall in the same cycle, status bit 0 ends cleared.
- R7: A word write to offset 0x00 or 0x28 changes nothing and responds with `rspRoErr` and `rspErr` high.
- R8: An access with `reqSize` other than word (encoding 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 reserved) responds with `rspWidthErr` and `rspErr` high and read data zero. It changes no state, including the timeout flag, and does not raise `rspRoErr`.
- R9: A word access to any offset other than 0x00, 0x20 or 0x28 reads zero, responds with `rspErr` high and `rspRoErr` low, and changes no state.
- R10: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high.
- R11: A word read of a mapped offset responds with all error outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset within the agent |
| reqSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| reqWdata | input | 32 | Write data |
| timeoutEvent | input | 1 | One-cycle pulse that sets the timeout flag |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspRdata | output | 32 | Read data; zero for writes and errors |
| rspErr | output | 1 | Any error on the responded access |
| rspRoErr | output | 1 | Write to a read-only register |
| rspWidthErr | output | 1 | Access not a full word |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, the registers at 0x00, 0x20 and 0x28, the 0x01000700 mask, a control reset value of 0x200 and the "TAG1" identifier. With an 8-bit offset, the unmapped neighbours 0x04 and 0x24 can be reached, as can every size encoding. The sticky flag is driven through set, clear, same-cycle set-and-clear and rejected-clear sequences, and a mid-run reset shows that it and control return to their reset values.

// File: rtl/tgt_agent_pkg.sv
package tgt_agent_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ID   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     accept;
    logic     ctrlWr;
    logic     clrTimeout;
    reg_sel_e rdSel;
    logic     errMap;
    logic     errRo;
    logic     errWidth;
  } strobe_t;
endpackage

// File: rtl/tgt_agent_ctrl.sv
module tgt_agent_ctrl
  import tgt_agent_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ID_OFF   = 'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h28
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              wdataBit0,
  output strobe_t           strb
);
  logic isWord, hitId, hitCtrl, hitStat, mapped, goodAcc;

  always_comb begin
    isWord  = (reqSize == SZ_WORD);
    hitId   = (reqAddr == ID_OFF);
    hitCtrl = (reqAddr == CTRL_OFF);
    hitStat = (reqAddr == STAT_OFF);
    mapped  = hitId | hitCtrl | hitStat;
    goodAcc = reqValid & isWord;

    strb            = '0;
    strb.accept     = reqValid;
    strb.errWidth   = reqValid & ~isWord;
    strb.errMap     = goodAcc & ~mapped;
    strb.errRo      = goodAcc & reqWrite & (hitId | hitStat);
    strb.ctrlWr     = goodAcc & reqWrite & hitCtrl;
    strb.clrTimeout = goodAcc & reqWrite & hitCtrl & wdataBit0;

    if (goodAcc && !reqWrite) begin
      if (hitId)        strb.rdSel = SEL_ID;
      else if (hitCtrl) strb.rdSel = SEL_CTRL;
      else if (hitStat) strb.rdSel = SEL_STAT;
      else              strb.rdSel = SEL_NONE;
    end else begin
      strb.rdSel = SEL_NONE;
    end
  end
endmodule

// File: rtl/tgt_agent_dpath.sv
module tgt_agent_dpath
  import tgt_agent_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE  = 32'h5441_4731,
  parameter logic [DATA_W-1:0] CTRL_MASK = 32'h0100_0700,
  parameter logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              timeoutEvent,
  output logic [DATA_W-1:0] ctrlValue,
  output logic              timeoutFlag,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspMapErr,
  output logic              rspRoErr,
  output logic              rspWidthErr
);
  localparam int STAT_PAD = DATA_W - 1;

  logic [DATA_W-1:0] ctrlQ;
  logic              toFlagQ;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    case (strb.rdSel)
      SEL_ID:   rdMux = ID_VALUE;
      SEL_CTRL: rdMux = ctrlQ;
      SEL_STAT: rdMux = {{STAT_PAD{1'b0}}, toFlagQ};
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RST & CTRL_MASK;
    end else if (strb.ctrlWr) begin
      ctrlQ <= reqWdata & CTRL_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlagQ <= 1'b0;
    end else if (strb.clrTimeout) begin
      toFlagQ <= 1'b0;
    end else if (timeoutEvent) begin
      toFlagQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspRdata    <= '0;
      rspMapErr   <= 1'b0;
      rspRoErr    <= 1'b0;
      rspWidthErr <= 1'b0;
    end else begin
      rspValid    <= strb.accept;
      rspRdata    <= rdMux;
      rspMapErr   <= strb.errMap;
      rspRoErr    <= strb.errRo;
      rspWidthErr <= strb.errWidth;
    end
  end

  assign ctrlValue   = ctrlQ;
  assign timeoutFlag = toFlagQ;
endmodule

// File: rtl/tgt_agent_regs.sv
module tgt_agent_regs
  import tgt_agent_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ID_OFF    = 'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF  = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFF  = 'h28,
  parameter logic [31:0]       ID_VALUE  = 32'h5441_4731,
  parameter logic [31:0]       CTRL_MASK = 32'h0100_0700,
  parameter logic [31:0]       CTRL_RST  = 32'h0000_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  input  logic              timeoutEvent,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  output logic              rspRoErr,
  output logic              rspWidthErr
);
  strobe_t           strb;
  logic [DATA_W-1:0] ctrlValue;
  logic              timeoutFlag;
  logic              rspMapErr;

  tgt_agent_ctrl #(
    .ADDR_W  (ADDR_W),
    .ID_OFF  (ID_OFF),
    .CTRL_OFF(CTRL_OFF),
    .STAT_OFF(STAT_OFF)
  ) ctrl_i (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .wdataBit0(reqWdata[0]),
    .strb     (strb)
  );

  tgt_agent_dpath #(
    .ID_VALUE (ID_VALUE),
    .CTRL_MASK(CTRL_MASK),
    .CTRL_RST (CTRL_RST)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqWdata    (reqWdata),
    .timeoutEvent(timeoutEvent),
    .ctrlValue   (ctrlValue),
    .timeoutFlag (timeoutFlag),
    .rspValid    (rspValid),
    .rspRdata    (rspRdata),
    .rspMapErr   (rspMapErr),
    .rspRoErr    (rspRoErr),
    .rspWidthErr (rspWidthErr)
  );

  assign rspErr = rspMapErr | rspRoErr | rspWidthErr;
endmodule

// File: rtl/tgt_agent_regs_chk.sv
module tgt_agent_regs_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ID_OFF   = 'h00,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h20,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h28
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              wdataBit0,
  input logic              timeoutEvent,
  input logic              rspValid,
  input logic [31:0]       rspRdata,
  input logic              rspErr,
  input logic              rspRoErr,
  input logic              rspWidthErr,
  input logic [31:0]       ctrlValue,
  input logic              timeoutFlag
);
  logic word, mapped, ctrlWrite, clrReq, roWrite;
  assign word      = reqValid && (reqSize == 2'b10);
  assign mapped    = (reqAddr == ID_OFF) || (reqAddr == CTRL_OFF) || (reqAddr == STAT_OFF);
  assign ctrlWrite = word && reqWrite && (reqAddr == CTRL_OFF);
  assign clrReq    = ctrlWrite && wdataBit0;
  assign roWrite   = word && reqWrite && ((reqAddr == ID_OFF) || (reqAddr == STAT_OFF));

  AST_RSP_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R10
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R10
  AST_WIDTH_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != 2'b10) |=> (rspWidthErr && rspErr && !rspRoErr && rspRdata == 32'h0)); // R8
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(ctrlValue)); // R3
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rstN)
    (word && !mapped) |=> (rspErr && !rspRoErr && rspRdata == 32'h0)); // R9
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    roWrite |=> (rspRoErr && rspErr)); // R7
  AST_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvent && !clrReq) |=> timeoutFlag); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> !timeoutFlag); // R6
  AST_GOOD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (word && !reqWrite && mapped) |=> !rspErr); // R11
endmodule

bind tgt_agent_regs tgt_agent_regs_chk #(
  .ADDR_W  (ADDR_W),
  .ID_OFF  (ID_OFF),
  .CTRL_OFF(CTRL_OFF),
  .STAT_OFF(STAT_OFF)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqAddr     (reqAddr),
  .reqSize     (reqSize),
  .wdataBit0   (reqWdata[0]),
  .timeoutEvent(timeoutEvent),
  .rspValid    (rspValid),
  .rspRdata    (rspRdata),
  .rspErr      (rspErr),
  .rspRoErr    (rspRoErr),
  .rspWidthErr (rspWidthErr),
  .ctrlValue   (ctrlValue),
  .timeoutFlag (timeoutFlag)
);

// File: tb/tgt_agent_regs_tb_top.sv
`timescale 1ns/1ps
module tgt_agent_regs_tb_top;
  localparam logic [31:0] ID = 32'h5441_4731;
  localparam logic [1:0] WD = 2'b10, SB = 2'b00, SH = 2'b01, SR = 2'b11;

  typedef struct packed {
    logic [3:0]  req;
    logic        valid;
    logic        write;
    logic [7:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        tmo;
    logic [31:0] expData;
    logic        expErr;
    logic        expRo;
    logic        expWid;
  } vec_t;

  function automatic vec_t mk(input logic [3:0] r, input logic v, input logic w,
                              input logic [7:0] a, input logic [1:0] s, input logic [31:0] d,
                              input logic t, input logic [31:0] ed, input logic ee,
                              input logic er, input logic ew);
    mk = '{r, v, w, a, s, d, t, ed, ee, er, ew};
  endfunction

  localparam int NV = 27;
  localparam vec_t VECS[NV] = '{
    mk(4'd2,  1,0,8'h00,WD,32'h0,          0, ID,            0,0,0), // R2 id read
    mk(4'd1,  1,0,8'h20,WD,32'h0,          0, 32'h200,       0,0,0), // R1 ctrl reset
    mk(4'd1,  1,0,8'h28,WD,32'h0,          0, 32'h0,         0,0,0), // R1 status reset
    mk(4'd3,  1,1,8'h20,WD,32'hFFFF_FFFE,  0, 32'h0,         0,0,0), // R3 write all ones
    mk(4'd3,  1,0,8'h20,WD,32'h0,          0, 32'h0100_0700, 0,0,0), // R3 masked readback
    mk(4'd5,  0,0,8'h00,WD,32'h0,          1, 32'h0,         0,0,0), // R5 timeout pulse
    mk(4'd5,  1,0,8'h28,WD,32'h0,          0, 32'h1,         0,0,0), // R5 flag set
    mk(4'd4,  1,1,8'h20,WD,32'h0000_0201,  0, 32'h0,         0,0,0), // R4 clearing write
    mk(4'd4,  1,0,8'h28,WD,32'h0,          0, 32'h0,         0,0,0), // R4 flag cleared
    mk(4'd4,  1,0,8'h20,WD,32'h0,          0, 32'h200,       0,0,0), // R4 bit0 not stored
    mk(4'd6,  1,1,8'h20,WD,32'h1,          1, 32'h0,         0,0,0), // R6 clear + event
    mk(4'd6,  1,0,8'h28,WD,32'h0,          0, 32'h0,         0,0,0), // R6 clear won
    mk(4'd7,  1,1,8'h00,WD,32'hDEAD_BEEF,  0, 32'h0,         1,1,0), // R7 id write
    mk(4'd7,  1,0,8'h00,WD,32'h0,          0, ID,            0,0,0), // R7 id intact
    mk(4'd5,  0,0,8'h00,WD,32'h0,          1, 32'h0,         0,0,0), // R5 set again
    mk(4'd7,  1,1,8'h28,WD,32'h0,          0, 32'h0,         1,1,0), // R7 status write
    mk(4'd7,  1,0,8'h28,WD,32'h0,          0, 32'h1,         0,0,0), // R7 status intact
    mk(4'd9,  1,0,8'h24,WD,32'h0,          0, 32'h0,         1,0,0), // R9 unmapped read
    mk(4'd9,  1,1,8'h04,WD,32'h701,        0, 32'h0,         1,0,0), // R9 unmapped write
    mk(4'd9,  1,0,8'h20,WD,32'h0,          0, 32'h0,         0,0,0), // R9 ctrl untouched
    mk(4'd8,  1,1,8'h20,SB,32'h0100_0701,  0, 32'h0,         1,0,1), // R8 byte write
    mk(4'd8,  1,0,8'h20,WD,32'h0,          0, 32'h0,         0,0,0), // R8 ctrl untouched
    mk(4'd8,  1,0,8'h20,SH,32'h0,          0, 32'h0,         1,0,1), // R8 half read
    mk(4'd8,  1,1,8'h28,SR,32'h0,          0, 32'h0,         1,0,1), // R8 reserved size, no RO flag
    mk(4'd8,  1,0,8'h28,WD,32'h0,          0, 32'h1,         0,0,0), // R8 flag kept
    mk(4'd11, 1,0,8'h00,WD,32'h0,          0, ID,            0,0,0), // R11 good read
    mk(4'd10, 0,0,8'h20,WD,32'h0,          0, 32'h0,         0,0,0)  // R10 idle, no response
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, timeoutEvent = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [1:0]  reqSize = WD;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr, rspRoErr, rspWidthErr;
  logic [31:0] rspRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tgt_agent_regs dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .timeoutEvent(timeoutEvent), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspErr(rspErr), .rspRoErr(rspRoErr), .rspWidthErr(rspWidthErr)
  );

  task automatic checkRsp(input int r, input logic v, input logic [31:0] d,
                          input logic e, input logic ro, input logic w);
    checks++;
    if ({rspValid, rspRdata, rspErr, rspRoErr, rspWidthErr} !== {v, d, e, ro, w}) begin
      errors++;
      $display("FAIL R%0d: got valid=%b data=%h err=%b ro=%b wid=%b, expected valid=%b data=%h err=%b ro=%b wid=%b",
               r, rspValid, rspRdata, rspErr, rspRoErr, rspWidthErr, v, d, e, ro, w);
    end
  endtask

  task automatic access(input logic v, input logic w, input logic [7:0] a,
                        input logic [1:0] s, input logic [31:0] d, input logic t);
    reqValid = v; reqWrite = w; reqAddr = a; reqSize = s; reqWdata = d; timeoutEvent = t;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; timeoutEvent = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkRsp(1, 0, 32'h0, 0, 0, 0); // R1 quiet in reset
    rstN = 1'b1;
    @(negedge clk);
    checkRsp(1, 0, 32'h0, 0, 0, 0); // R1 quiet after reset
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].valid, VECS[i].write, VECS[i].addr, VECS[i].size,
             VECS[i].wdata, VECS[i].tmo);
      checkRsp(int'(VECS[i].req), VECS[i].valid, VECS[i].expData,
               VECS[i].expErr, VECS[i].expRo, VECS[i].expWid);
    end
    // R5: flag stays set across idle cycles
    repeat (5) access(1'b0, 1'b0, 8'h00, WD, 32'h0, 1'b0);
    access(1'b1, 1'b0, 8'h28, WD, 32'h0, 1'b0);
    checkRsp(5, 1, 32'h1, 0, 0, 0);
    // R3: set a control field, then reset mid-run
    access(1'b1, 1'b1, 8'h20, WD, 32'h0100_0400, 1'b0);
    checkRsp(3, 1, 32'h0, 0, 0, 0);
    rstN = 1'b0;
    @(negedge clk);
    checkRsp(1, 0, 32'h0, 0, 0, 0); // R1 outputs cleared by reset
    rstN = 1'b1;
    @(negedge clk);
    access(1'b1, 1'b0, 8'h20, WD, 32'h0, 1'b0);
    checkRsp(1, 1, 32'h200, 0, 0, 0); // R1 ctrl back to reset value
    access(1'b1, 1'b0, 8'h28, WD, 32'h0, 1'b0);
    checkRsp(1, 1, 32'h0, 0, 0, 0);   // R1 flag cleared by reset
    // R10: back-to-back requests each get a response, then drop
    access(1'b1, 1'b0, 8'h00, WD, 32'h0, 1'b0);
    checkRsp(10, 1, ID, 0, 0, 0);
    @(negedge clk);
    checkRsp(10, 0, 32'h0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule